// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block prepares an asynchronous EDO DRAM for use and then keeps its contents alive. After reset it holds the memory idle for a programmable settling time. It then issues eight refresh cycles and raises a ready flag, which tells the access controller it may start normal traffic. From then on, an interval timer adds one owed refresh at a fixed period. Each owed refresh is served only after the access controller grants the bus.

Every refresh cycle uses CAS-before-RAS ordering, so the DRAM's internal row counter supplies the row and the block produces no row address. While the block owns the bus, it drives the row strobe and a shared group of column strobes. It holds the write enable inactive and drives the address bus with zeros. If the controller withholds the bus, owed refreshes accumulate in a saturating backlog counter, and a grant later drains them back to back. All durations are counted in clock cycles and set by parameters.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted and right after it, `ras_n`, every bit of `cas_n` and `we_n` are 1. `addr` is 0. `rfsh_req`, `drive_en` and `init_done` are 0, and `pend_cnt` is 0.
- R2: After reset is released, `rfsh_req` stays 0 for the first `INIT_WAIT_CLKS - 1` rising edges. It is 1 after edge `INIT_WAIT_CLKS`, when `INIT_RFSH` refreshes become owed.
- R3: `init_done` rises only when the last of the `INIT_RFSH` start-up refresh cycles completes, with nothing owed and the bus released. It then stays 1 until reset.
- R4: A refresh cycle starts only on an edge where `rfsh_req` and `rfsh_gnt` are both 1. While `drive_en` is 1, `rfsh_req` is 0. While `drive_en` is 0, `ras_n` and all `cas_n` bits are 1. A held grant with nothing owed starts no cycle.
- R5: In every refresh cycle, all `cas_n` bits go low at least `T_CSR` clocks before `ras_n` falls. They are still low when `ras_n` falls and stay low for at least `T_CHR` clocks after the fall.
- R6: `ras_n` stays low for exactly `T_RAS` clocks. Between cycles it stays high for at least `T_RP` clocks. Successive falls of `ras_n` are at least `T_RC` clocks apart.
- R7: Whenever `drive_en` is 1, `we_n` is 1 and `addr` is all zeros.
- R8: Once `init_done` is 1, the owed count grows by one every `RFSH_INTERVAL_CLKS` clocks while no grant is given.
- R9: `pend_cnt` never exceeds `PEND_MAX`; a timer tick that finds the count at `PEND_MAX` is dropped. A grant then performs exactly `min(ticks, PEND_MAX)` refresh cycles before `rfsh_req` falls.
- R10: Asserting reset in the middle of a refresh cycle returns every output to the R1 state at once. The start-up wait then begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_gnt | input | 1 | Bus grant from the access controller |
| rfsh_req | output | 1 | Refresh owed and sequencer idle; asks for the bus |
| drive_en | output | 1 | Sequencer is driving the DRAM control and address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_W | Column strobes, all driven together, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ADDR_W | Address bus, zeros while driving |
| init_done | output | 1 | Start-up sequence complete |
| pend_cnt | output | $clog2(PEND_MAX+1) | Number of refreshes currently owed |

## Verification
A wrong phase counter in the cycle state machine shows up within one refresh cycle. It appears as a `ras_n` low time other than `T_RAS`, or as `cas_n` released too early after the row strobe falls. A wrong backlog value shows up after the next timer tick as a wrong `pend_cnt`. It also shows up at the next grant as a wrong number of row-strobe pulses. A stuck start-up phase appears as `init_done` rising after the wrong number of pulses, or never rising.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ACT   = 2'd2,
      ST_PRE   = 2'd3
   } cyc_st_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
   parameter int INIT_WAIT_CLKS     = 40000,
   parameter int RFSH_INTERVAL_CLKS = 3120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic wait_done_o,
   output logic wait_pulse_o,
   output logic tick_o
);
   localparam int IW = $clog2(INIT_WAIT_CLKS + 1);
   localparam int TW = $clog2(RFSH_INTERVAL_CLKS + 1);
   localparam logic [IW-1:0] WAIT_LAST = IW'(INIT_WAIT_CLKS - 1);
   localparam logic [TW-1:0] TICK_LAST = TW'(RFSH_INTERVAL_CLKS - 1);

   logic [IW-1:0] wait_cnt;
   logic [TW-1:0] tick_cnt;
   logic          wait_done;

   // start-up settling counter, runs once per reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt  <= '0;
         wait_done <= 1'b0;
      end else if (!wait_done) begin
         if (wait_cnt == WAIT_LAST) wait_done <= 1'b1;
         else                       wait_cnt  <= wait_cnt + 1'b1;
      end
   end

   assign wait_done_o  = wait_done;
   assign wait_pulse_o = !wait_done && (wait_cnt == WAIT_LAST);

   // periodic interval counter, held at zero until enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tick_cnt <= '0;
      else if (!run_en)              tick_cnt <= '0;
      else if (tick_cnt == TICK_LAST) tick_cnt <= '0;
      else                           tick_cnt <= tick_cnt + 1'b1;
   end

   assign tick_o = run_en && (tick_cnt == TICK_LAST);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
   parameter int PEND_MAX  = 8,
   parameter int INIT_RFSH = 8,
   parameter int PW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          tick_i,
   input  logic          done_i,
   output logic [PW-1:0] cnt_o
);
   logic [PW-1:0] cnt;
   logic          inc;

   always_comb inc = tick_i && (cnt != PW'(PEND_MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (load_i) cnt <= PW'(INIT_RFSH);
      else begin
         case ({inc, done_i})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign cnt_o = cnt;

endmodule

// File: rtl/rfsh_cbr_fsm.sv
module rfsh_cbr_fsm
   import dram_rfsh_pkg::*;
#(
   parameter int T_CSR    = 1,
   parameter int T_CHR    = 2,
   parameter int T_RAS    = 10,
   parameter int PRE_CLKS = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o,
   output logic ras_n_o,
   output logic cas_n_o
);
   localparam int CW = $clog2(imax(imax(T_CSR, T_RAS), PRE_CLKS) + 1);

   cyc_st_e       st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start_i) begin st <= ST_SETUP; cnt <= '0; end
            ST_SETUP:
               if (cnt == CW'(T_CSR - 1)) begin st <= ST_ACT; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            ST_ACT:
               if (cnt == CW'(T_RAS - 1)) begin st <= ST_PRE; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            ST_PRE:
               if (cnt == CW'(PRE_CLKS - 1)) begin st <= ST_IDLE; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            default: begin st <= ST_IDLE; cnt <= '0; end
         endcase
      end
   end

   assign busy_o  = (st != ST_IDLE);
   assign done_o  = (st == ST_PRE) && (cnt == CW'(PRE_CLKS - 1));
   assign ras_n_o = (st != ST_ACT);
   assign cas_n_o = !((st == ST_SETUP) || ((st == ST_ACT) && (cnt < CW'(T_CHR))));

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
   import dram_rfsh_pkg::*;
#(
   parameter int  ADDR_W             = 11,
   parameter int  CAS_W              = 4,
   parameter int  INIT_WAIT_CLKS     = 40000,
   parameter int  RFSH_INTERVAL_CLKS = 3120,
   parameter int  INIT_RFSH          = 8,
   parameter int  PEND_MAX           = 8,
   parameter int  T_CSR              = 1,
   parameter int  T_CHR              = 2,
   parameter int  T_RAS              = 10,
   parameter int  T_RP               = 6,
   parameter int  T_RC               = 18,
   localparam int PW                 = $clog2(PEND_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rfsh_gnt,
   output logic              rfsh_req,
   output logic              drive_en,
   output logic              ras_n,
   output logic [CAS_W-1:0]  cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done,
   output logic [PW-1:0]     pend_cnt
);
   localparam int PRE_CLKS = imax(T_RP, T_RC - T_CSR - T_RAS);

   // parameter sanity
   if (T_CSR < 1)                 begin : g_bad_csr   $error("T_CSR must be at least 1"); end
   if (T_CHR < 1 || T_CHR >= T_RAS) begin : g_bad_chr $error("T_CHR must lie in 1..T_RAS-1"); end
   if (T_RP < 1)                  begin : g_bad_rp    $error("T_RP must be at least 1"); end
   if (INIT_RFSH < 1 || INIT_RFSH > PEND_MAX) begin : g_bad_init $error("INIT_RFSH must lie in 1..PEND_MAX"); end
   if (INIT_WAIT_CLKS < 1 || RFSH_INTERVAL_CLKS < 2) begin : g_bad_tmr $error("timer periods too short"); end

   logic wait_done, wait_pulse, tick;
   logic busy, cyc_done, ras_int, cas_int, start;
   logic init_phase;

   rfsh_timer #(
      .INIT_WAIT_CLKS    (INIT_WAIT_CLKS),
      .RFSH_INTERVAL_CLKS(RFSH_INTERVAL_CLKS)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (init_done),
      .wait_done_o (wait_done),
      .wait_pulse_o(wait_pulse),
      .tick_o      (tick)
   );

   rfsh_backlog #(
      .PEND_MAX (PEND_MAX),
      .INIT_RFSH(INIT_RFSH),
      .PW       (PW)
   ) u_backlog (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(wait_pulse),
      .tick_i(tick),
      .done_i(cyc_done),
      .cnt_o (pend_cnt)
   );

   rfsh_cbr_fsm #(
      .T_CSR   (T_CSR),
      .T_CHR   (T_CHR),
      .T_RAS   (T_RAS),
      .PRE_CLKS(PRE_CLKS)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .busy_o (busy),
      .done_o (cyc_done),
      .ras_n_o(ras_int),
      .cas_n_o(cas_int)
   );

   assign rfsh_req = wait_done && (pend_cnt != '0) && !busy;
   assign start    = rfsh_req && rfsh_gnt;
   assign drive_en = busy;
   assign ras_n    = ras_int;
   assign cas_n    = {CAS_W{cas_int}};
   assign we_n     = 1'b1;
   assign addr     = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_phase <= 1'b0;
         init_done  <= 1'b0;
      end else begin
         if (wait_pulse) init_phase <= 1'b1;
         if (init_phase && cyc_done && (pend_cnt == PW'(1))) begin
            init_phase <= 1'b0;
            init_done  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dram_rfsh_seq_chk.sv
module dram_rfsh_seq_chk #(
   parameter int T_RAS    = 10,
   parameter int PEND_MAX = 8,
   parameter int PW       = 4,
   parameter int CAS_W    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ras_n,
   input logic [CAS_W-1:0] cas_n,
   input logic             drive_en,
   input logic             rfsh_req,
   input logic             init_done,
   input logic [PW-1:0]    pend_cnt
);
   logic [15:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low_run <= '0;
      else if (!ras_n) low_run <= low_run + 1'b1;
      else            low_run <= '0;
   end

   a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (cas_n == '0) && $past(cas_n == '0));

   a_r6_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (int'(low_run) == T_RAS));

   a_r9_backlog_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pend_cnt) <= PEND_MAX);

   a_r4_quiet_req: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> !rfsh_req);

   a_r4_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |-> ras_n && (cas_n == '1));

   a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   a_r3_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (pend_cnt == '0) && !drive_en);

endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk #(
   .T_RAS   (T_RAS),
   .PEND_MAX(PEND_MAX),
   .PW      (PW),
   .CAS_W   (CAS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .drive_en (drive_en),
   .rfsh_req (rfsh_req),
   .init_done(init_done),
   .pend_cnt (pend_cnt)
);

// File: tb/dram_rfsh_seq_tb.sv
`timescale 1ns/1ps
module dram_rfsh_seq_tb_top;
   localparam int ADDR_W   = 11;
   localparam int CAS_W    = 4;
   localparam int INIT_W   = 60;
   localparam int INTV     = 400;
   localparam int INIT_N   = 8;
   localparam int PMAX     = 8;
   localparam int T_CSR    = 1;
   localparam int T_CHR    = 2;
   localparam int T_RAS    = 10;
   localparam int T_RP     = 6;
   localparam int T_RC     = 18;
   localparam int PW       = $clog2(PMAX + 1);
   localparam int NVEC     = 5;
   // {ticks withheld, expected owed count and expected cycles on grant}
   localparam int VEC [NVEC][2] = '{'{1, 1}, '{3, 3}, '{8, 8}, '{10, 8}, '{12, 8}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rfsh_gnt = 1'b0;
   logic rfsh_req, drive_en, ras_n, we_n, init_done;
   logic [CAS_W-1:0]  cas_n;
   logic [ADDR_W-1:0] addr;
   logic [PW-1:0]     pend_cnt;

   int errors = 0;
   int checks = 0;
   int nfall  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   dram_rfsh_seq #(
      .ADDR_W(ADDR_W), .CAS_W(CAS_W), .INIT_WAIT_CLKS(INIT_W),
      .RFSH_INTERVAL_CLKS(INTV), .INIT_RFSH(INIT_N), .PEND_MAX(PMAX),
      .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
      .drive_en(drive_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .addr(addr), .init_done(init_done), .pend_cnt(pend_cnt)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic chk_idle(input string rq);
      chk(ras_n && (cas_n == '1) && we_n && (addr == '0), {rq, " strobes idle"},
          {ras_n, cas_n}, {1'b1, {CAS_W{1'b1}}});
      chk(!rfsh_req && !drive_en && !init_done && (pend_cnt == '0), {rq, " flags clear"},
          {rfsh_req, drive_en, init_done, pend_cnt}, 0);
   endtask

   // waveform-shape monitor for R4..R7
   int   cas_low_run = 0, ras_low_run = 0, ras_high_run = 1000, since_fall = 1000, chr_run = 0;
   logic p_ras = 1'b1, p_cas = 1'b1;
   always @(negedge clk) begin
      if (!rst_n) begin
         cas_low_run = 0; ras_low_run = 0; ras_high_run = 1000; since_fall = 1000; chr_run = 0;
         p_ras = 1'b1; p_cas = 1'b1;
      end else begin
         if (p_ras && !ras_n) begin
            nfall++;
            chk(cas_low_run >= T_CSR, "R5 cas lead", cas_low_run, T_CSR);
            chk(cas_n == '0, "R5 cas low at ras fall", int'(cas_n), 0);
            chk(ras_high_run >= T_RP, "R6 precharge", ras_high_run, T_RP);
            chk(since_fall >= T_RC, "R6 cycle time", since_fall, T_RC);
            since_fall = 0;
         end
         if (!p_ras && ras_n)
            chk(ras_low_run == T_RAS, "R6 ras width", ras_low_run, T_RAS);
         if (!p_cas && cas_n[0] && !ras_n)
            chk(chr_run >= T_CHR, "R5 cas hold", chr_run, T_CHR);
         if (drive_en) begin
            chk(we_n && (addr == '0), "R7 we/addr", int'(addr), 0);
            chk(!rfsh_req, "R4 req quiet while driving", rfsh_req, 0);
         end else begin
            chk(ras_n && (cas_n == '1), "R4 bus released", {ras_n, cas_n}, {1'b1, {CAS_W{1'b1}}});
         end
         cas_low_run  = (cas_n == '0) ? cas_low_run + 1 : 0;
         ras_low_run  = ras_n ? 0 : ras_low_run + 1;
         ras_high_run = ras_n ? ras_high_run + 1 : 0;
         if (!ras_n && (cas_n == '0)) chr_run++;
         else if (ras_n)              chr_run = 0;
         since_fall++;
         p_ras = ras_n;
         p_cas = cas_n[0];
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=completion", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int f0;
      int guard;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk_idle("R1");
      rst_n = 1'b1;

      // R2: exact start of the first request
      repeat (INIT_W - 1) @(negedge clk);
      chk(!rfsh_req, "R2 early req", rfsh_req, 0);
      chk(pend_cnt == '0, "R2 nothing owed yet", pend_cnt, 0);
      @(negedge clk);
      chk(rfsh_req, "R2 req after wait", rfsh_req, 1);
      chk(pend_cnt == PW'(INIT_N), "R2 start-up load", pend_cnt, INIT_N);

      // R3: start-up cycles
      f0 = nfall;
      rfsh_gnt = 1'b1;
      guard = 0;
      while (!init_done && guard < 2000) begin @(negedge clk); guard++; end
      chk(init_done, "R3 init_done rose", init_done, 1);
      chk(nfall - f0 == INIT_N, "R3 start-up cycle count", nfall - f0, INIT_N);
      chk(pend_cnt == '0 && !drive_en, "R3 clean finish", pend_cnt, 0);
      rfsh_gnt = 1'b0;

      // R8/R9: table of withheld ticks
      for (int i = 0; i < NVEC; i++) begin
         guard = 0;
         while (pend_cnt == '0 && guard < 2 * INTV) begin @(negedge clk); guard++; end
         f0 = nfall;
         repeat ((VEC[i][0] - 1) * INTV + INTV / 2) @(negedge clk);
         chk(int'(pend_cnt) == VEC[i][1], "R8/R9 owed count", pend_cnt, VEC[i][1]);
         chk(nfall == f0, "R4 no cycle without grant", nfall - f0, 0);
         chk(init_done, "R3 init_done holds", init_done, 1);
         rfsh_gnt = 1'b1;
         @(negedge clk);
         guard = 0;
         while ((rfsh_req || drive_en) && guard < 1000) begin @(negedge clk); guard++; end
         chk(nfall - f0 == VEC[i][1], "R9 drained cycles", nfall - f0, VEC[i][1]);
         f0 = nfall;
         repeat (30) @(negedge clk);
         chk(nfall == f0 && pend_cnt == '0, "R4 grant with nothing owed", nfall - f0, 0);
         rfsh_gnt = 1'b0;
      end

      // R10: reset in the middle of a cycle
      guard = 0;
      while (pend_cnt == '0 && guard < 2 * INTV) begin @(negedge clk); guard++; end
      rfsh_gnt = 1'b1;
      guard = 0;
      while (!drive_en && guard < 50) begin @(negedge clk); guard++; end
      repeat (4) @(negedge clk);
      chk(!ras_n, "R10 inside cycle before reset", ras_n, 0);
      rst_n = 1'b0;
      #1;
      chk_idle("R10");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (INIT_W - 1) @(negedge clk);
      chk(!rfsh_req && !drive_en && ras_n, "R10 wait restarted", rfsh_req, 0);
      rfsh_gnt = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule